// File: doc/BRIEF.md
# Transactional Snoop Response Unit

This unit sits beside a small fully associative transactional cache and answers the shared-bus requests issued by other processors. For each observed request it looks the address up in the cache's entry array, which is presented to it as flattened per-entry address, tag, line-state and data fields. It then decides whether the local cache stays silent, supplies the line's data, or refuses the request with a BUSY answer. When it supplies data it may also demote or invalidate the line, and it flags when the supplied data is modified and must be absorbed by memory as a write-back.

The unit runs in one of two ways for each request. In regular mode it behaves like an ordinary snooping cache and sees only entries tagged normal. Regular mode applies when the local transaction has already aborted, or when the request is a plain read or read-for-ownership. In transactional mode it protects the live transaction's working set. That mode applies when the local transaction is still live and the request is a transactional read or a transactional read-for-ownership. A transactional read may share a clean shared copy, and every other attempt to take the line is refused. A silent answer tells the memory controller that it must respond itself.

The datapath is a fixed two-register pipeline with no stall. A request is sampled together with a snapshot of the lookup result. In the next cycle the decision stage picks one of five actions. IGNORE means a miss. SHARE is a regular read. GIVE is a regular ownership transfer. LEND is a transactional read of a shared entry. REFUSE answers BUSY. The registered answer appears one cycle after that. Requests may arrive every cycle.

Top module: `tsnoop_resp`

## Requirements
- R1: A request with `snp_valid` high in cycle n produces `rsp_valid` high for exactly cycle n+2. `rsp_valid` is low in any cycle whose cycle-minus-two had no request, and when `rsp_valid` is low, `rsp_kind` is 0 (none) and `upd_valid` is 0. Response codes are 0 none, 1 data, 2 busy.
- R2: An entry takes part in a lookup only if its address equals `snp_addr` and its line state is not 0 (invalid). Line states are 0 invalid, 1 shared, 2 exclusive clean and 3 exclusive dirty. When no entry qualifies, the answer is none, with `upd_valid`=0 and `rsp_wb`=0, and memory answers the request.
- R3: Regular mode applies when `tx_live`=0, or when `snp_kind` is 0 (READ) or 1 (RFO). In regular mode only entries tagged 1 (normal) are considered. Tags are 0 empty, 1 normal, 2 drop-on-commit and 3 drop-on-abort, so an entry tagged 2 or 3 yields none.
- R4: In regular mode, a READ (0) or T_READ (2) hit answers data carrying the entry's data. An exclusive line (state 2 or 3) gets `upd_valid`=1 with `upd_state`=1, and a shared line gets no update.
- R5: In regular mode, an RFO (1) or T_RFO (3) hit answers data and sets `upd_valid`=1 with `upd_state`=0 for the matched entry.
- R6: `rsp_wb` is 1 exactly when the answer is data and the supplying line was in state 3 (dirty).
- R7: Transactional mode applies when `tx_live`=1 and `snp_kind` is 2 or 3. It picks a drop-on-commit match first and a drop-on-abort match second. Within any one tag class, the lowest entry index wins, and that index is reported on `upd_idx` and selects `rsp_data`.
- R8: In transactional mode, a T_READ to a matched entry in state 1 answers data with no update and no write-back.
- R9: In transactional mode, any other request answers busy, with `upd_valid`=0, `rsp_wb`=0 and `rsp_data`=0. This covers a T_RFO, or a T_READ to an exclusive entry.
- R10: When a transactional-mode request finds no drop-on-commit or drop-on-abort match, it is handled in regular mode against the normal-tagged entries.
- R11: Entry fields and `tx_live` are used as they stand in the request cycle. A retag or state change in a later cycle does not alter that request's answer.
- R12: While `rst_n` is low, all outputs are 0.
- R13: Requests in consecutive cycles are each answered in consecutive cycles, in order, and each answer depends only on its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_valid | input | 1 | A bus request is present this cycle |
| snp_kind | input | 2 | Request type: 0 READ, 1 RFO, 2 T_READ, 3 T_RFO |
| snp_addr | input | AW | Requested line address |
| tx_live | input | 1 | Local transaction has not aborted |
| ent_addr | input | N*AW | Entry i address at [i*AW +: AW] |
| ent_tag | input | N*2 | Entry i transactional tag at [i*2 +: 2] |
| ent_state | input | N*2 | Entry i line state at [i*2 +: 2] |
| ent_data | input | N*DW | Entry i data at [i*DW +: DW] |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_kind | output | 2 | Answer: 0 none, 1 data, 2 busy |
| rsp_data | output | DW | Supplied data, 0 unless the answer is data |
| upd_valid | output | 1 | Line state of entry `upd_idx` is to change |
| upd_idx | output | IW | Entry index of the matched line |
| upd_state | output | 2 | New line state for that entry |
| rsp_wb | output | 1 | Supplied data is modified and is also written to memory |

## Verification
The lookup of a new request can fall in the same cycle as a local commit or abort retag. The bench provokes this by rewriting the entry tags, states and `tx_live` on the cycle right after the request is sampled. The answer is judged against the pre-retag view: a drop-on-commit shared line is still lent, and a normal dirty line is still demoted even though it has since been retagged. The second overlap is a fresh request sampled in the same cycle that the previous request is being decided. The bench issues two requests back to back with different entry contents and checks both answers in their own cycles.

// File: rtl/tsnoop_pkg.sv
package tsnoop_pkg;
    localparam int KIND_W = 2;
    localparam int TAG_W  = 2;
    localparam int ST_W   = 2;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_RFO   = 2'd1,
        RQ_TREAD = 2'd2,
        RQ_TRFO  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        TG_EMPTY       = 2'd0,
        TG_NORMAL      = 2'd1,
        TG_DROP_COMMIT = 2'd2,
        TG_DROP_ABORT  = 2'd3
    } ent_tag_e;

    typedef enum logic [1:0] {
        LS_INVALID    = 2'd0,
        LS_SHARED     = 2'd1,
        LS_EXCL_CLEAN = 2'd2,
        LS_EXCL_DIRTY = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_DATA = 2'd1,
        RSP_BUSY = 2'd2,
        RSP_RSVD = 2'd3
    } rsp_kind_e;

    // decision classes of the second pipeline stage
    typedef enum logic [2:0] {
        ACT_IGNORE = 3'd0,
        ACT_SHARE  = 3'd1,
        ACT_GIVE   = 3'd2,
        ACT_LEND   = 3'd3,
        ACT_REFUSE = 3'd4
    } act_e;
endpackage

// File: rtl/tsnoop_match.sv
module tsnoop_match
    import tsnoop_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int IW = 2
) (
    input  logic [AW-1:0]      req_addr,
    input  logic [KIND_W-1:0]  req_kind,
    input  logic               tx_live,
    input  logic [N*AW-1:0]    ent_addr,
    input  logic [N*TAG_W-1:0] ent_tag,
    input  logic [N*ST_W-1:0]  ent_state,
    input  logic [N*DW-1:0]    ent_data,
    output logic               hit,
    output logic               tx_mode,
    output logic [IW-1:0]      idx,
    output logic [ST_W-1:0]    state,
    output logic [DW-1:0]      data
);
    logic [N-1:0] held, m_norm, m_com, m_abt, sel;
    logic         tx_req;

    for (genvar gi = 0; gi < N; gi++) begin : g_ent
        assign held[gi]   = (ent_addr[gi*AW +: AW] == req_addr) &&
                            (ent_state[gi*ST_W +: ST_W] != LS_INVALID);
        assign m_norm[gi] = held[gi] && (ent_tag[gi*TAG_W +: TAG_W] == TG_NORMAL);
        assign m_com[gi]  = held[gi] && (ent_tag[gi*TAG_W +: TAG_W] == TG_DROP_COMMIT);
        assign m_abt[gi]  = held[gi] && (ent_tag[gi*TAG_W +: TAG_W] == TG_DROP_ABORT);
    end

    // live transaction and a transactional request type
    assign tx_req = tx_live && req_kind[1];

    function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) r = IW'(i);
        end
        return r;
    endfunction

    always_comb begin
        tx_mode = 1'b0;
        if (tx_req && (|m_com)) begin
            sel     = m_com;
            tx_mode = 1'b1;
        end else if (tx_req && (|m_abt)) begin
            sel     = m_abt;
            tx_mode = 1'b1;
        end else begin
            sel     = m_norm;
        end
        hit   = |sel;
        idx   = lowest_set(sel);
        state = ent_state[int'(idx)*ST_W +: ST_W];
        data  = ent_data[int'(idx)*DW +: DW];
    end
endmodule

// File: rtl/tsnoop_decide.sv
module tsnoop_decide
    import tsnoop_pkg::*;
(
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    input  logic              hit,
    input  logic              tx_mode,
    input  logic [ST_W-1:0]   state,
    output act_e              act,
    output rsp_kind_e         rsp,
    output logic              upd,
    output line_state_e       upd_state,
    output logic              wb
);
    always_comb begin
        if (!valid || !hit) begin
            act = ACT_IGNORE;
        end else if (tx_mode) begin
            act = (kind == RQ_TREAD && state == LS_SHARED) ? ACT_LEND : ACT_REFUSE;
        end else begin
            act = kind[0] ? ACT_GIVE : ACT_SHARE;
        end
    end

    always_comb begin
        rsp       = RSP_NONE;
        upd       = 1'b0;
        upd_state = LS_INVALID;
        wb        = 1'b0;
        unique case (act)
            ACT_IGNORE: ;
            ACT_SHARE: begin
                rsp       = RSP_DATA;
                upd       = state[1];
                upd_state = LS_SHARED;
                wb        = (state == LS_EXCL_DIRTY);
            end
            ACT_GIVE: begin
                rsp       = RSP_DATA;
                upd       = 1'b1;
                upd_state = LS_INVALID;
                wb        = (state == LS_EXCL_DIRTY);
            end
            ACT_LEND:   rsp = RSP_DATA;
            ACT_REFUSE: rsp = RSP_BUSY;
            default:    rsp = RSP_NONE;
        endcase
    end
endmodule

// File: rtl/tsnoop_resp.sv
module tsnoop_resp
    import tsnoop_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snp_valid,
    input  logic [1:0]         snp_kind,
    input  logic [AW-1:0]      snp_addr,
    input  logic               tx_live,
    input  logic [N*AW-1:0]    ent_addr,
    input  logic [N*2-1:0]     ent_tag,
    input  logic [N*2-1:0]     ent_state,
    input  logic [N*DW-1:0]    ent_data,
    output logic               rsp_valid,
    output logic [1:0]         rsp_kind,
    output logic [DW-1:0]      rsp_data,
    output logic               upd_valid,
    output logic [IW-1:0]      upd_idx,
    output logic [1:0]         upd_state,
    output logic               rsp_wb
);
    logic            m_hit, m_tx;
    logic [IW-1:0]   m_idx;
    logic [ST_W-1:0] m_state;
    logic [DW-1:0]   m_data;

    tsnoop_match #(.N(N), .AW(AW), .DW(DW), .IW(IW)) u_match (
        .req_addr (snp_addr),
        .req_kind (snp_kind),
        .tx_live  (tx_live),
        .ent_addr (ent_addr),
        .ent_tag  (ent_tag),
        .ent_state(ent_state),
        .ent_data (ent_data),
        .hit      (m_hit),
        .tx_mode  (m_tx),
        .idx      (m_idx),
        .state    (m_state),
        .data     (m_data)
    );

    // stage 1: request and lookup snapshot
    logic            s1_valid, s1_hit, s1_tx;
    logic [1:0]      s1_kind;
    logic [IW-1:0]   s1_idx;
    logic [ST_W-1:0] s1_state;
    logic [DW-1:0]   s1_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_tx    <= 1'b0;
            s1_kind  <= '0;
            s1_idx   <= '0;
            s1_state <= '0;
            s1_data  <= '0;
        end else begin
            s1_valid <= snp_valid;
            s1_hit   <= snp_valid && m_hit;
            s1_tx    <= m_tx;
            s1_kind  <= snp_kind;
            s1_idx   <= m_idx;
            s1_state <= m_state;
            s1_data  <= m_data;
        end
    end

    act_e        d_act;
    rsp_kind_e   d_rsp;
    logic        d_upd, d_wb;
    line_state_e d_ust;

    tsnoop_decide u_decide (
        .valid    (s1_valid),
        .kind     (s1_kind),
        .hit      (s1_hit),
        .tx_mode  (s1_tx),
        .state    (s1_state),
        .act      (d_act),
        .rsp      (d_rsp),
        .upd      (d_upd),
        .upd_state(d_ust),
        .wb       (d_wb)
    );

    // stage 2: registered answer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= RSP_NONE;
            rsp_data  <= '0;
            upd_valid <= 1'b0;
            upd_idx   <= '0;
            upd_state <= LS_INVALID;
            rsp_wb    <= 1'b0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_kind  <= d_rsp;
            rsp_data  <= (d_act == ACT_IGNORE || d_act == ACT_REFUSE) ? '0 : s1_data;
            upd_valid <= d_upd;
            upd_idx   <= (d_act == ACT_IGNORE) ? '0 : s1_idx;
            upd_state <= d_ust;
            rsp_wb    <= d_wb;
        end
    end
endmodule

// File: rtl/tsnoop_resp_chk.sv
module tsnoop_resp_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          snp_valid,
    input logic          rsp_valid,
    input logic [1:0]    rsp_kind,
    input logic [DW-1:0] rsp_data,
    input logic          upd_valid,
    input logic [1:0]    upd_state,
    input logic          rsp_wb
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (rsp_valid == $past(snp_valid, 2)));            // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_kind == 2'd0 && !upd_valid && !rsp_wb));              // R1
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd0) |-> (!upd_valid && !rsp_wb));             // R2
    AST_UPD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (rsp_kind == 2'd1 && (upd_state == 2'd0 || upd_state == 2'd1))); // R4
    AST_WB_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb |-> (rsp_valid && rsp_kind == 2'd1));                              // R6
    AST_BUSY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == 2'd2) |-> (!upd_valid && !rsp_wb && rsp_data == '0));        // R9
    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_kind != 2'd3);                                                        // R1
endmodule

bind tsnoop_resp tsnoop_resp_chk #(.DW(DW)) u_chk (.*);

// File: tb/tsnoop_resp_tb.sv
`timescale 1ns/1ps
module tsnoop_resp_tb;
    localparam int N = 4, AW = 16, DW = 32, IW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            snp_valid = 1'b0;
    logic [1:0]      snp_kind = '0;
    logic [AW-1:0]   snp_addr = '0;
    logic            tx_live = 1'b0;
    logic [N*AW-1:0] ent_addr = {16'h0200, 16'h0100, 16'h0100, 16'h0100};
    logic [N*2-1:0]  ent_tag = '0;
    logic [N*2-1:0]  ent_state = '0;
    logic [N*DW-1:0] ent_data = {32'hCAFE0003, 32'hCAFE0002, 32'hCAFE0001, 32'hCAFE0000};
    logic            rsp_valid, upd_valid, rsp_wb;
    logic [1:0]      rsp_kind, upd_state;
    logic [DW-1:0]   rsp_data;
    logic [IW-1:0]   upd_idx;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tsnoop_resp u_dut (.*);

    typedef struct packed {
        logic [1:0]  kind;
        logic        tx;
        logic [15:0] addr;
        logic [7:0]  tags;   // entry3..entry0, 2 bits each
        logic [7:0]  sts;
        logic [1:0]  ersp;
        logic [1:0]  eidx;
        logic        eupd;
        logic [1:0]  est;
        logic        ewb;
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t VECS [0:14] = '{
        '{2'd0, 1'b1, 16'h0200, 8'b01_00_00_00, 8'b11_00_00_00, 2'd1, 2'd3, 1'b1, 2'd1, 1'b1, 8'd4},  // R4 READ dirty
        '{2'd2, 1'b0, 16'h0200, 8'b01_00_00_00, 8'b10_00_00_00, 2'd1, 2'd3, 1'b1, 2'd1, 1'b0, 8'd4},  // R4 T_READ clean, aborted
        '{2'd0, 1'b0, 16'h0200, 8'b01_00_00_00, 8'b01_00_00_00, 2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 8'd4},  // R4 shared no update
        '{2'd1, 1'b1, 16'h0200, 8'b01_00_00_00, 8'b11_00_00_00, 2'd1, 2'd3, 1'b1, 2'd0, 1'b1, 8'd5},  // R5 RFO dirty
        '{2'd3, 1'b0, 16'h0200, 8'b01_00_00_00, 8'b01_00_00_00, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 8'd5},  // R5 T_RFO aborted
        '{2'd0, 1'b1, 16'h0100, 8'b00_00_11_10, 8'b00_00_11_01, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 8'd3},  // R3 plain READ
        '{2'd2, 1'b0, 16'h0100, 8'b00_00_11_10, 8'b00_00_11_01, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 8'd3},  // R3 aborted tx
        '{2'd2, 1'b1, 16'h0100, 8'b00_00_11_10, 8'b00_00_11_01, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 8'd8},  // R8 lend
        '{2'd2, 1'b1, 16'h0100, 8'b00_00_10_11, 8'b00_00_10_01, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 8'd7},  // R7 commit first
        '{2'd3, 1'b1, 16'h0100, 8'b00_00_00_10, 8'b00_00_00_01, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 8'd9},  // R9 T_RFO busy
        '{2'd2, 1'b1, 16'h0100, 8'b00_11_11_00, 8'b00_01_01_00, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 8'd7},  // R7 lowest index
        '{2'd3, 1'b1, 16'h0100, 8'b00_01_00_00, 8'b00_11_00_00, 2'd1, 2'd2, 1'b1, 2'd0, 1'b1, 8'd10}, // R10 fallback
        '{2'd0, 1'b0, 16'h0300, 8'b01_00_00_00, 8'b11_00_00_00, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 8'd2},  // R2 addr miss
        '{2'd0, 1'b0, 16'h0100, 8'b00_00_00_01, 8'b00_00_00_00, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 8'd2},  // R2 invalid line
        '{2'd0, 1'b0, 16'h0100, 8'b00_01_01_00, 8'b00_11_01_00, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 8'd7}   // R7 normal lowest
    };

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        snp_valid = 1'b1;
        snp_kind  = v.kind;
        snp_addr  = v.addr;
        tx_live   = v.tx;
        ent_tag   = v.tags;
        ent_state = v.sts;
    endtask

    task automatic judge(input vec_t v);
        string rq;
        rq = $sformatf("R%0d", v.rq);
        chk(rq, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rq, "rsp_kind", 64'(rsp_kind), 64'(v.ersp));
        chk(rq, "rsp_data", 64'(rsp_data), (v.ersp == 2'd1) ? 64'(32'hCAFE0000 | 32'(v.eidx)) : 64'd0);
        chk(rq, "upd_valid", 64'(upd_valid), 64'(v.eupd));
        if (v.eupd) begin
            chk(rq, "upd_state", 64'(upd_state), 64'(v.est));
            chk(rq, "upd_idx", 64'(upd_idx), 64'(v.eidx));
        end
        chk("R6", "rsp_wb", 64'(rsp_wb), 64'(v.ewb));
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk); drive(v);
        @(posedge clk);
        @(negedge clk); snp_valid = 1'b0;
        chk("R1", "early strobe", 64'(rsp_valid), 64'd0);
        @(posedge clk);
        @(negedge clk); judge(v);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "strobe width", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        vec_t va, vb;
        repeat (3) @(negedge clk);
        chk("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12", "reset rsp_kind", 64'(rsp_kind), 64'd0);
        chk("R12", "reset upd_valid", 64'(upd_valid), 64'd0);
        chk("R12", "reset rsp_data", 64'(rsp_data), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) run_vec(VECS[i]);

        // R11: retag right after sampling; lent from drop-on-commit entry
        va = VECS[7];
        @(negedge clk); drive(va);
        @(posedge clk);
        @(negedge clk); snp_valid = 1'b0; ent_tag = '0; tx_live = 1'b0;
        @(posedge clk);
        @(negedge clk);
        va.rq = 8'd11; judge(va);

        // R11: normal dirty line retagged to drop-on-abort after sampling
        va = VECS[0];
        @(negedge clk); drive(va);
        @(posedge clk);
        @(negedge clk); snp_valid = 1'b0; ent_tag = 8'b11_00_00_00; ent_state = 8'b01_00_00_00;
        @(posedge clk);
        @(negedge clk);
        va.rq = 8'd11; judge(va);

        // R13: back-to-back requests with different entry contents
        va = VECS[3]; va.rq = 8'd13;
        vb = VECS[7]; vb.rq = 8'd13;
        @(negedge clk); drive(va);
        @(posedge clk);
        @(negedge clk); drive(vb);
        @(posedge clk);
        @(negedge clk); snp_valid = 1'b0; judge(va);
        @(posedge clk);
        @(negedge clk); judge(vb);
        @(posedge clk);
        @(negedge clk);
        chk("R13", "no third strobe", 64'(rsp_valid), 64'd0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule